// File: doc/BRIEF.md
# Little-Endian Address Munging Unit

This block sits between a big-endian load/store pipeline and a 64-bit data bus. It lets the core run little-endian code without any byte-lane swapping: each little-endian access has its low address bits flipped by a constant that depends on the operand size. The result is that a narrow operand lands in the mirrored byte position of the bus word, which is exactly where a little-endian view expects it. Doubleword and 128-bit vector accesses need no flip. This means a doubleword written in one mode reads back unchanged in the other mode.

The active endian state is a register that resets to big-endian. Software can rewrite it at any time. On interrupt entry it is reloaded from a separate interrupt-endian bit, so that a handler can run in a different byte order from the code it interrupted. Page-table walk accesses bypass the flip in every mode. In little-endian mode, an access that is not naturally aligned is refused with a fault pulse instead of being issued.

Top module: `le_addr_munger`

## Requirements
- R1: During and right after reset, `le_active`, `bus_valid` and `align_fault` are all 0, which means big-endian mode with no access pending.
- R2: A software write (`mode_wr_en`=1) loads `mode_wr_val` into the active mode at the clock edge. An access presented in the same cycle still uses the old mode, and the next access uses the new one. The mode holds when there is neither a write nor an interrupt entry.
- R3: A pulse on `irq_entry` loads `irq_le` into the active mode at that edge. It wins over a software write in the same cycle.
- R4: In little-endian mode, a normal access has address bits [2:0] XORed with a constant chosen by `req_size`. The codes and constants are: 0 = byte, XOR 3'b111; 1 = halfword, XOR 3'b110; 2 = word, XOR 3'b100; 3 = doubleword, XOR 3'b000; 4 = 128-bit vector, XOR 3'b000.
- R5: A page-table walk access (`req_walk`=1) is issued with its address unchanged and never faults, whatever the mode.
- R6: In little-endian mode, a normal access that is not naturally aligned sets `align_fault` for one cycle, one cycle later, and `bus_valid` stays 0. Natural alignment means: halfword needs addr[0]=0; word needs addr[1:0]=0; doubleword needs addr[2:0]=0; vector needs addr[3:0]=0.
- R7: In big-endian mode, every access is issued with its address unchanged and never faults, even when misaligned.
- R8: `bus_valid` and `bus_addr` are registered, with one cycle from `req_valid` to the output. Address bits above bit 2 pass through unchanged.
- R9: Doubleword and vector accesses to the same address produce the same bus address in both modes, so stored data round-trips across a mode switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_addr | input | ADDR_W | Effective address |
| req_size | input | 3 | Operand size code (see R4) |
| req_walk | input | 1 | 1 = page-table walk access |
| mode_wr_en | input | 1 | Software write of the endian mode |
| mode_wr_val | input | 1 | Value written, 1 = little-endian |
| irq_le | input | 1 | Endian mode to take on interrupt entry |
| irq_entry | input | 1 | Interrupt-entry pulse |
| bus_valid | output | 1 | Issued access valid |
| bus_addr | output | ADDR_W | Munged bus address |
| align_fault | output | 1 | Little-endian misalignment refusal |
| le_active | output | 1 | Active endian mode, 1 = little-endian |

## Verification
The bench targets the cycle in which a mode write coincides with an access. A design that applied the new mode early would flip the address of that access. It also targets an interrupt entry that collides with a software write; getting the priority wrong leaves the handler in the wrong byte order. Misaligned accesses are driven in both modes and as table walks, which catches a fault that fires in big-endian mode or on walks, as well as an access that leaks onto the bus after faulting. Doubleword and vector addresses are compared across a mode switch, together with high address bits, which exposes a wrong constant or a flip that reaches beyond bit 2.

// File: rtl/endian_pkg.sv
package endian_pkg;

   typedef enum logic [2:0] {
      ACC_BYTE = 3'd0,
      ACC_HALF = 3'd1,
      ACC_WORD = 3'd2,
      ACC_DBL  = 3'd3,
      ACC_VEC  = 3'd4
   } acc_size_e;

   // log2 of the operand length in bytes
   function automatic int unsigned acc_log2(input acc_size_e s, input int unsigned vec_log2);
      case (s)
         ACC_BYTE: return 0;
         ACC_HALF: return 1;
         ACC_WORD: return 2;
         ACC_DBL:  return 3;
         ACC_VEC:  return vec_log2;
         default:  return 3;
      endcase
   endfunction

endpackage

// File: rtl/endian_mode_reg.sv
module endian_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_wr_en,
   input  logic sw_wr_val,
   input  logic irq_entry,
   input  logic irq_le,
   output logic le_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         le_q <= 1'b0;
      else if (irq_entry)
         le_q <= irq_le;
      else if (sw_wr_en)
         le_q <= sw_wr_val;
   end
endmodule

// File: rtl/endian_lane_xor.sv
module endian_lane_xor
   import endian_pkg::*;
#(
   parameter int unsigned LANE_BITS = 3,
   parameter int unsigned VEC_LOG2  = 4
) (
   input  acc_size_e             size,
   input  logic                  xlate_en,
   input  logic [LANE_BITS-1:0]  lo_in,
   output logic [LANE_BITS-1:0]  lo_out
);
   int unsigned          len_lg;
   logic [LANE_BITS-1:0] flip;

   always_comb begin
      len_lg = acc_log2(size, VEC_LOG2);
      if (len_lg > LANE_BITS) len_lg = LANE_BITS;
      for (int i = 0; i < LANE_BITS; i++)
         flip[i] = (i >= len_lg);
      lo_out = xlate_en ? (lo_in ^ flip) : lo_in;
   end
endmodule

// File: rtl/endian_align_chk.sv
module endian_align_chk
   import endian_pkg::*;
#(
   parameter int unsigned LANE_BITS   = 3,
   parameter int unsigned VEC_LOG2    = 4,
   parameter bit          VEC_NATURAL = 1'b1,
   localparam int unsigned VEC_AL     = VEC_NATURAL ? VEC_LOG2 : LANE_BITS,
   localparam int unsigned CHK_BITS   = (VEC_AL > LANE_BITS) ? VEC_AL : LANE_BITS
) (
   input  acc_size_e            size,
   input  logic [CHK_BITS-1:0]  lo_addr,
   output logic                 misaligned
);
   int unsigned al_lg;

   always_comb begin
      al_lg      = acc_log2(size, VEC_AL);
      misaligned = 1'b0;
      for (int i = 0; i < CHK_BITS; i++)
         if (i < al_lg && lo_addr[i]) misaligned = 1'b1;
   end
endmodule

// File: rtl/le_addr_munger.sv
module le_addr_munger
   import endian_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned BUS_BYTES   = 8,
   parameter int unsigned VEC_BYTES   = 16,
   parameter bit          VEC_NATURAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_size,
   input  logic              req_walk,
   input  logic              mode_wr_en,
   input  logic              mode_wr_val,
   input  logic              irq_le,
   input  logic              irq_entry,
   output logic              bus_valid,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              align_fault,
   output logic              le_active
);
   localparam int unsigned LANE_BITS = $clog2(BUS_BYTES);
   localparam int unsigned VEC_LOG2  = $clog2(VEC_BYTES);
   localparam int unsigned VEC_AL    = VEC_NATURAL ? VEC_LOG2 : LANE_BITS;
   localparam int unsigned CHK_BITS  = (VEC_AL > LANE_BITS) ? VEC_AL : LANE_BITS;

   generate
      if (BUS_BYTES < 8 || (BUS_BYTES & (BUS_BYTES - 1)) != 0) begin : g_bad_bus
         $error("BUS_BYTES must be a power of two of at least 8");
      end
      if (VEC_BYTES < BUS_BYTES || (VEC_BYTES & (VEC_BYTES - 1)) != 0) begin : g_bad_vec
         $error("VEC_BYTES must be a power of two not below BUS_BYTES");
      end
      if (ADDR_W <= CHK_BITS) begin : g_bad_aw
         $error("ADDR_W too narrow for the alignment check");
      end
   endgenerate

   acc_size_e             size_e;
   logic                  le_q;
   logic                  xlate_en;
   logic                  misal;
   logic                  fault_now;
   logic                  issue_now;
   logic [LANE_BITS-1:0]  lo_munged;

   assign size_e = acc_size_e'(req_size);

   endian_mode_reg u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_wr_en  (mode_wr_en),
      .sw_wr_val (mode_wr_val),
      .irq_entry (irq_entry),
      .irq_le    (irq_le),
      .le_q      (le_q)
   );

   assign xlate_en = le_q & ~req_walk;

   endian_lane_xor #(.LANE_BITS(LANE_BITS), .VEC_LOG2(VEC_LOG2)) u_xor (
      .size     (size_e),
      .xlate_en (xlate_en),
      .lo_in    (req_addr[LANE_BITS-1:0]),
      .lo_out   (lo_munged)
   );

   endian_align_chk #(
      .LANE_BITS   (LANE_BITS),
      .VEC_LOG2    (VEC_LOG2),
      .VEC_NATURAL (VEC_NATURAL)
   ) u_align (
      .size       (size_e),
      .lo_addr    (req_addr[CHK_BITS-1:0]),
      .misaligned (misal)
   );

   assign fault_now = req_valid & xlate_en & misal;
   assign issue_now = req_valid & ~fault_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_valid   <= 1'b0;
         align_fault <= 1'b0;
         bus_addr    <= '0;
      end else begin
         bus_valid   <= issue_now;
         align_fault <= fault_now;
         if (issue_now)
            bus_addr <= {req_addr[ADDR_W-1:LANE_BITS], lo_munged};
      end
   end

   assign le_active = le_q;

endmodule

// File: rtl/le_addr_munger_chk.sv
module le_addr_munger_chk #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned LANE_BITS = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_walk,
   input logic              mode_wr_en,
   input logic              irq_le,
   input logic              irq_entry,
   input logic              bus_valid,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              align_fault,
   input logic              le_active
);
   // R1: reset state
   always @(posedge clk)
      if (!rst_n) a_r1_reset_state: assert (!le_active && !bus_valid && !align_fault);

   // R2: mode holds without a write or an interrupt entry
   a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_wr_en && !irq_entry) |=> $stable(le_active));

   // R3: interrupt entry loads the interrupt-endian bit
   a_r3_irq_load: assert property (@(posedge clk) disable iff (!rst_n)
      irq_entry |=> (le_active == $past(irq_le)));

   // R5: walks pass through unmodified
   a_r5_walk_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_walk) |=> (bus_valid && !align_fault && bus_addr == $past(req_addr)));

   // R6: a faulted access is never issued
   a_r6_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> !bus_valid);

   // R7: big-endian mode is an identity
   a_r7_be_identity: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !le_active) |=> (bus_valid && bus_addr == $past(req_addr)));

   // R8: upper bits unchanged
   a_r8_high_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !align_fault) ##1 bus_valid |->
         bus_addr[ADDR_W-1:LANE_BITS] == $past(req_addr[ADDR_W-1:LANE_BITS]));
endmodule

bind le_addr_munger le_addr_munger_chk #(.ADDR_W(ADDR_W), .LANE_BITS(LANE_BITS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_addr    (req_addr),
   .req_walk    (req_walk),
   .mode_wr_en  (mode_wr_en),
   .irq_le      (irq_le),
   .irq_entry   (irq_entry),
   .bus_valid   (bus_valid),
   .bus_addr    (bus_addr),
   .align_fault (align_fault),
   .le_active   (le_active)
);

// File: tb/sim_le_addr_munger.sv
module sim_le_addr_munger;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [2:0]    req_size = '0;
   logic          req_walk = 1'b0;
   logic          mode_wr_en = 1'b0;
   logic          mode_wr_val = 1'b0;
   logic          irq_le = 1'b0;
   logic          irq_entry = 1'b0;
   logic          bus_valid;
   logic [AW-1:0] bus_addr;
   logic          align_fault;
   logic          le_active;

   int n_checks = 0;
   int n_fail = 0;
   bit model_le = 1'b0;
   logic [AW-1:0] saved_be;
   logic [AW-1:0] last_issued = '0;

   always #4 clk = ~clk;

   le_addr_munger u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_walk(req_walk), .mode_wr_en(mode_wr_en),
      .mode_wr_val(mode_wr_val), .irq_le(irq_le), .irq_entry(irq_entry),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .align_fault(align_fault),
      .le_active(le_active)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // one cycle: drive at negedge, predict, compare after the edge
   task automatic cyc(input bit v, input logic [AW-1:0] a, input int sz, input bit walk,
                      input bit wr, input bit wv, input bit irq, input bit il, input string tag);
      bit le_eff, mis, flt, ev;
      logic [2:0] k;
      logic [AW-1:0] ea;
      bit nxt;
      @(negedge clk);
      req_valid = v; req_addr = a; req_size = 3'(sz); req_walk = walk;
      mode_wr_en = wr; mode_wr_val = wv; irq_entry = irq; irq_le = il;
      le_eff = model_le && !walk;
      case (sz)
         0: begin k = 3'b111; mis = 0; end
         1: begin k = 3'b110; mis = a[0]; end
         2: begin k = 3'b100; mis = (a[1:0] != 0); end
         3: begin k = 3'b000; mis = (a[2:0] != 0); end
         default: begin k = 3'b000; mis = (a[3:0] != 0); end
      endcase
      flt = v && le_eff && mis;
      ev  = v && !flt;
      ea  = le_eff ? (a ^ AW'(k)) : a;
      if (ev) last_issued = ea;
      nxt = irq ? il : (wr ? wv : model_le);
      @(posedge clk);
      #1;
      check({tag, " bus_valid"}, 64'(bus_valid), 64'(ev));
      check({tag, " align_fault"}, 64'(align_fault), 64'(flt));
      if (ev) check({tag, " bus_addr"}, 64'(bus_addr), 64'(last_issued));
      check({tag, " le_active"}, 64'(le_active), 64'(nxt));
      model_le = nxt;
   endtask

   initial begin
      #(8 * 200000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      #20;
      check("R1 le_active", 64'(le_active), 64'd0);
      check("R1 bus_valid", 64'(bus_valid), 64'd0);
      check("R1 align_fault", 64'(align_fault), 64'd0);
      @(negedge clk); rst_n = 1'b1;
      #1; check("R1 after release", 64'(le_active), 64'd0);

      // big-endian: identity, no fault even when misaligned
      cyc(1, 32'h1000_0003, 0, 0, 0, 0, 0, 0, "R7 be byte");
      cyc(1, 32'h1000_0005, 2, 0, 0, 0, 0, 0, "R7 be word misaligned");
      cyc(1, 32'h1000_0009, 4, 0, 0, 0, 0, 0, "R7 be vec misaligned");
      cyc(0, 32'h0, 0, 0, 0, 0, 0, 0, "R8 idle");
      // write to little-endian with an access the same cycle (old mode)
      cyc(1, 32'hABCD_0011, 0, 0, 1, 1, 0, 0, "R2 same-cycle access");
      // little-endian aligned sizes
      cyc(1, 32'hABCD_0011, 0, 0, 0, 0, 0, 0, "R4 byte");
      cyc(1, 32'hABCD_0016, 1, 0, 0, 0, 0, 0, "R4 half");
      cyc(1, 32'hABCD_0014, 2, 0, 0, 0, 0, 0, "R4 word");
      cyc(1, 32'hABCD_0018, 3, 0, 0, 0, 0, 0, "R4 dbl");
      cyc(1, 32'hABCD_0020, 4, 0, 0, 0, 0, 0, "R4 vec");
      // little-endian misaligned
      cyc(1, 32'hABCD_0013, 1, 0, 0, 0, 0, 0, "R6 half misaligned");
      cyc(1, 32'hABCD_0016, 2, 0, 0, 0, 0, 0, "R6 word misaligned");
      cyc(1, 32'hABCD_001C, 3, 0, 0, 0, 0, 0, "R6 dbl misaligned");
      cyc(1, 32'hABCD_0028, 4, 0, 0, 0, 0, 0, "R6 vec misaligned");
      // walks bypass
      cyc(1, 32'h7000_0005, 0, 1, 0, 0, 0, 0, "R5 walk byte");
      cyc(1, 32'h7000_0007, 2, 1, 0, 0, 0, 0, "R5 walk misaligned");
      // doubleword round trip: LE address, then BE address must match
      cyc(1, 32'h5555_0040, 3, 0, 0, 0, 0, 0, "R9 dbl le");
      saved_be = bus_addr;
      cyc(1, 32'h0, 0, 0, 1, 0, 0, 0, "R2 write be");
      cyc(1, 32'h5555_0040, 3, 0, 0, 0, 0, 0, "R9 dbl be");
      check("R9 dbl same address", 64'(bus_addr), 64'(saved_be));
      // interrupt entry beats a same-cycle write
      cyc(0, 32'h0, 0, 0, 1, 0, 1, 1, "R3 irq over write");
      cyc(1, 32'h0000_0102, 1, 0, 0, 0, 0, 0, "R3 handler in le");
      cyc(0, 32'h0, 0, 0, 1, 1, 1, 0, "R3 irq to be");
      cyc(0, 32'h0, 0, 0, 0, 0, 0, 0, "R2 hold");
      // high bits pass through under both modes
      for (int i = 0; i < 40; i++) begin
         logic [AW-1:0] a;
         a = 32'h9E37_79B9 * (i + 1);
         cyc(1, a, i % 5, (i % 7) == 3, (i % 6) == 0, i[1], (i % 11) == 5, i[0], "R8 sweep");
      end
      cyc(0, 32'h0, 0, 0, 0, 0, 0, 0, "R8 drain");
      finish_up();
   end
endmodule